// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power state of a processor core from cycle to cycle. A halt pulse parks the core in an auto-halt state, and any wake event brings it back. An active-low stop-clock request starts a handshake. First the controller asks the bus unit to issue a stop-grant acknowledge cycle. It then waits a fixed number of bus clocks after that cycle's response before it declares the core stopped. Only at that point does it drop the clock enables of the sections that stop. From the stopped state, an active-low sleep request leads on to a deeper sleep state. A detected bus snoop leads to a short snoop-service state in which the cache section is clocked.

While the core is stopped, snoop-servicing or asleep, the interrupt-class wake events (bus-init, init, system-management and two local interrupt lines) are not serviced. Each one is latched instead. After the core returns to Normal, each latched event is replayed exactly once on a one-hot output, one per cycle, in a fixed priority order. A core reset input reinitialises the core. If it arrives while the core is stopped and the stop-clock request is still held, the core comes back to the stopped state rather than to Normal. Two sequencing errors are reported as one-cycle pulses: releasing stop-clock too early, and releasing it no later than sleep.

Top module: `pwr_state_top`

## Requirements
- R1: While `rstN` is low, `pwrState` is Normal (code 0), every bit of `clkEn` is high, and `ackReq`, `seqErr` and `evtReplay` are all zero. State codes are: Normal 0, AutoHALT 1, AckWait 2, EnterDelay 3, StopGrant 4, Snoop 5, Sleep 6, CoreInit 7.
- R2: A `haltPulse` in Normal moves the state to AutoHALT (code 1) on the next clock, with `clkEn` = HALT_KEEP (default 4'b0011). In AutoHALT, a low level on any of `smiN`, `binitN`, `initN`, `lintN[0]` or `lintN[1]` returns the state to Normal on the next clock.
- R3: A `rsmPulse` in Normal moves the state to AutoHALT when `rsmToHalt` is 1. When `rsmToHalt` is 0, the state stays Normal.
- R4: A low `stpClkN` in Normal or AutoHALT moves the state to AckWait on the next clock. `ackReq` is high exactly while the state is AckWait.
- R5: When `ackRsp` is sampled high in AckWait at clock edge T0, the state is EnterDelay from T0 through T0+19 with all `clkEn` high. It becomes StopGrant at edge T0+20, where `clkEn` = GRANT_KEEP (default 4'b0001).
- R6: A high `stpClkN` sampled in AckWait or EnterDelay returns the state to Normal. In the same clock it sets `seqErr[0]` for exactly one cycle.
- R7: In StopGrant, a high `stpClkN` returns the state to Normal on the next clock.
- R8: In StopGrant, a low `slpN` moves the state to Sleep (`clkEn` all zero). In Sleep, a high `slpN` returns the state to StopGrant. A high `stpClkN` sampled in Sleep sets `seqErr[1]` for one cycle.
- R9: In StopGrant, `snoopHit` moves the state to Snoop (`clkEn` = SNOOP_KEEP, default 4'b0011). `snoopDone` in Snoop returns it to StopGrant.
- R10: Wake events seen in StopGrant, Snoop or Sleep change no state. Each is latched once, however long or often it occurs. After the return to Normal, each latched event appears on `evtReplay` for exactly one cycle, starting one clock after Normal is entered, one per cycle. The order is bit0 bus-init, bit1 init, bit2 system-management, bit3 local line 0, bit4 local line 1.
- R11: A high `cpuReset` moves the state to CoreInit (all `clkEn` high) on the next clock and discards every latched event. After `cpuReset` falls, the state becomes StopGrant if the reset began in StopGrant, Snoop or Sleep and `stpClkN` is still low. Otherwise it becomes Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous block reset, active low |
| cpuReset | input | 1 | Core reset request, active high |
| haltPulse | input | 1 | One-cycle pulse: halt instruction executed |
| stpClkN | input | 1 | Stop-clock request, active low |
| slpN | input | 1 | Sleep request, active low |
| snoopHit | input | 1 | Bus snoop detected |
| snoopDone | input | 1 | Snoop service complete |
| ackRsp | input | 1 | Response phase of the stop-grant acknowledge cycle |
| rsmPulse | input | 1 | Return from system-management handler |
| rsmToHalt | input | 1 | Resume target: 1 AutoHALT, 0 Normal |
| smiN | input | 1 | System-management event, active low |
| binitN | input | 1 | Bus-init event, active low |
| initN | input | 1 | Init event, active low |
| lintN | input | 2 | Local interrupt lines, active low |
| pwrState | output | 3 | Current state code |
| clkEn | output | SECT | Per-section clock enables |
| ackReq | output | 1 | Request to issue the stop-grant acknowledge cycle |
| seqErr | output | 2 | bit0 early stop-clock release, bit1 release during sleep |
| evtReplay | output | 5 | One-hot replay of latched events |

## Verification
A wrong state code shows up at once on `pwrState`, and also on `clkEn` in the same cycle, because the enables are decoded from the state. An off-by-one in the entry delay is caught by checking the state on edges T0+19 and T0+20. A lost, doubled or misordered latch shows up in the replay cycles that follow the next return to Normal. There, a scoreboard holds the expected one-hot codes in order and flags any extra or missing pulse. Events latched before a core reset are checked by watching that no replay appears after the following return to Normal.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  localparam int NUM_EVT = 5;

  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_AUTOHALT  = 3'd1,
    ST_ACKWAIT   = 3'd2,
    ST_ENTER     = 3'd3,
    ST_STOPGRANT = 3'd4,
    ST_SNOOP     = 3'd5,
    ST_SLEEP     = 3'd6,
    ST_COREINIT  = 3'd7
  } pwr_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic countEn;
    logic latchEn;
    logic replayEn;
    logic clearEvt;
  } dp_ctl_t;

endpackage

// File: rtl/pwr_dp.sv
module pwr_dp
  import pwr_pkg::*;
#(
  parameter int DELAY = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctl_t            ctl,
  input  logic [NUM_EVT-1:0] evtAct,
  output logic               cntZero,
  output logic               wakeAny,
  output logic [NUM_EVT-1:0] evtReplay
);

  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY - 1);

  logic [CW-1:0]      cnt;
  logic [NUM_EVT-1:0] pend;
  logic [NUM_EVT-1:0] pick;
  logic [NUM_EVT-1:0] setMask;
  logic [NUM_EVT-1:0] clrMask;

  assign cntZero = (cnt == '0);
  assign wakeAny = |evtAct;

  // isolate lowest set bit: lowest index has highest priority
  assign pick    = pend & (~pend + NUM_EVT'(1));
  assign setMask = ctl.latchEn  ? evtAct : '0;
  assign clrMask = ctl.replayEn ? pick   : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadCnt) begin
      cnt <= LOAD_VAL;
    end else if (ctl.countEn && !cntZero) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= '0;
      evtReplay <= '0;
    end else if (ctl.clearEvt) begin
      pend      <= '0;
      evtReplay <= '0;
    end else begin
      pend      <= (pend | setMask) & ~clrMask;
      evtReplay <= clrMask;
    end
  end

  assert_replay_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evtReplay));

  assert_replay_in_normal_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|evtReplay) |-> $past(ctl.replayEn));

  assert_clear_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clearEvt) |-> (pend == '0));

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int             SECT       = 4,
  parameter logic [SECT-1:0] HALT_KEEP  = 4'b0011,
  parameter logic [SECT-1:0] GRANT_KEEP = 4'b0001,
  parameter logic [SECT-1:0] SNOOP_KEEP = 4'b0011,
  parameter logic [SECT-1:0] SLEEP_KEEP = 4'b0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuReset,
  input  logic            haltPulse,
  input  logic            stpClkN,
  input  logic            slpN,
  input  logic            snoopHit,
  input  logic            snoopDone,
  input  logic            ackRsp,
  input  logic            rsmPulse,
  input  logic            rsmToHalt,
  input  logic            wakeAny,
  input  logic            cntZero,
  output pwr_state_t      state,
  output logic            ackReq,
  output logic [SECT-1:0] clkEn,
  output logic [1:0]      seqErr,
  output dp_ctl_t         dpCtl
);

  pwr_state_t nextState;
  logic       stayGrant;
  logic       inGrantFamily;
  logic       earlyRel;
  logic       sleepRel;

  assign inGrantFamily = (state == ST_STOPGRANT) || (state == ST_SNOOP) ||
                         (state == ST_SLEEP);
  assign earlyRel = !cpuReset && stpClkN &&
                    ((state == ST_ACKWAIT) || (state == ST_ENTER));
  assign sleepRel = !cpuReset && stpClkN && (state == ST_SLEEP);

  always_comb begin
    nextState = state;
    if (cpuReset) begin
      nextState = ST_COREINIT;
    end else begin
      unique case (state)
        ST_NORMAL: begin
          if (!stpClkN)                 nextState = ST_ACKWAIT;
          else if (haltPulse)           nextState = ST_AUTOHALT;
          else if (rsmPulse && rsmToHalt) nextState = ST_AUTOHALT;
        end
        ST_AUTOHALT: begin
          if (wakeAny)       nextState = ST_NORMAL;
          else if (!stpClkN) nextState = ST_ACKWAIT;
        end
        ST_ACKWAIT: begin
          if (stpClkN)     nextState = ST_NORMAL;
          else if (ackRsp) nextState = ST_ENTER;
        end
        ST_ENTER: begin
          if (stpClkN)      nextState = ST_NORMAL;
          else if (cntZero) nextState = ST_STOPGRANT;
        end
        ST_STOPGRANT: begin
          if (stpClkN)       nextState = ST_NORMAL;
          else if (!slpN)    nextState = ST_SLEEP;
          else if (snoopHit) nextState = ST_SNOOP;
        end
        ST_SNOOP: begin
          if (snoopDone) nextState = ST_STOPGRANT;
        end
        ST_SLEEP: begin
          if (slpN) nextState = ST_STOPGRANT;
        end
        ST_COREINIT: begin
          nextState = (stayGrant && !stpClkN) ? ST_STOPGRANT : ST_NORMAL;
        end
        default: nextState = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_NORMAL;
      stayGrant <= 1'b0;
      seqErr    <= 2'b00;
    end else begin
      state  <= nextState;
      seqErr <= {sleepRel, earlyRel};
      if (cpuReset && state != ST_COREINIT) begin
        stayGrant <= inGrantFamily;
      end
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.loadCnt  = (state == ST_ACKWAIT) && ackRsp && !stpClkN && !cpuReset;
    dpCtl.countEn  = (state == ST_ENTER);
    dpCtl.latchEn  = inGrantFamily && !cpuReset;
    dpCtl.replayEn = (state == ST_NORMAL) && !cpuReset;
    dpCtl.clearEvt = cpuReset;
  end

  assign ackReq = (state == ST_ACKWAIT);

  always_comb begin
    unique case (state)
      ST_AUTOHALT:  clkEn = HALT_KEEP;
      ST_STOPGRANT: clkEn = GRANT_KEEP;
      ST_SNOOP:     clkEn = SNOOP_KEEP;
      ST_SLEEP:     clkEn = SLEEP_KEEP;
      default:      clkEn = '1;
    endcase
  end

  assert_reset_to_init_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReset |=> (state == ST_COREINIT));

  assert_grant_after_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPGRANT && $past(state) == ST_ENTER) |-> $past(cntZero));

  assert_snoop_from_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SNOOP) |-> ($past(state) == ST_STOPGRANT || $past(state) == ST_SNOOP));

  assert_early_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqErr[0] |-> (state == ST_NORMAL));

  assert_sleep_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_SLEEP && !$past(cpuReset)) |-> (state == ST_SLEEP || state == ST_STOPGRANT));

endmodule

// File: rtl/pwr_state_top.sv
module pwr_state_top
  import pwr_pkg::*;
#(
  parameter int SECT  = 4,
  parameter int DELAY = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReset,
  input  logic              haltPulse,
  input  logic              stpClkN,
  input  logic              slpN,
  input  logic              snoopHit,
  input  logic              snoopDone,
  input  logic              ackRsp,
  input  logic              rsmPulse,
  input  logic              rsmToHalt,
  input  logic              smiN,
  input  logic              binitN,
  input  logic              initN,
  input  logic [1:0]        lintN,
  output logic [2:0]        pwrState,
  output logic [SECT-1:0]   clkEn,
  output logic              ackReq,
  output logic [1:0]        seqErr,
  output logic [NUM_EVT-1:0] evtReplay
);

  pwr_state_t         stateQ;
  dp_ctl_t            dpCtl;
  logic               cntZero;
  logic               wakeAny;
  logic [NUM_EVT-1:0] evtAct;

  // priority order by index: bus-init, init, system-management, local 0, local 1
  assign evtAct   = {~lintN[1], ~lintN[0], ~smiN, ~initN, ~binitN};
  assign pwrState = stateQ;

  pwr_ctrl #(
    .SECT (SECT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReset  (cpuReset),
    .haltPulse (haltPulse),
    .stpClkN   (stpClkN),
    .slpN      (slpN),
    .snoopHit  (snoopHit),
    .snoopDone (snoopDone),
    .ackRsp    (ackRsp),
    .rsmPulse  (rsmPulse),
    .rsmToHalt (rsmToHalt),
    .wakeAny   (wakeAny),
    .cntZero   (cntZero),
    .state     (stateQ),
    .ackReq    (ackReq),
    .clkEn     (clkEn),
    .seqErr    (seqErr),
    .dpCtl     (dpCtl)
  );

  pwr_dp #(
    .DELAY (DELAY)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .evtAct    (evtAct),
    .cntZero   (cntZero),
    .wakeAny   (wakeAny),
    .evtReplay (evtReplay)
  );

endmodule

// File: tb/pwr_state_top_tb_top.sv
module pwr_state_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN, cpuReset, haltPulse, stpClkN, slpN, snoopHit, snoopDone;
  logic       ackRsp, rsmPulse, rsmToHalt, smiN, binitN, initN;
  logic [1:0] lintN;
  logic [2:0] pwrState;
  logic [3:0] clkEn;
  logic       ackReq;
  logic [1:0] seqErr;
  logic [4:0] evtReplay;

  int compared = 0;
  int mismatched = 0;
  logic [4:0] expQ[$];

  always #5 clk = ~clk;

  pwr_state_top dut_i (
    .clk(clk), .rstN(rstN), .cpuReset(cpuReset), .haltPulse(haltPulse),
    .stpClkN(stpClkN), .slpN(slpN), .snoopHit(snoopHit), .snoopDone(snoopDone),
    .ackRsp(ackRsp), .rsmPulse(rsmPulse), .rsmToHalt(rsmToHalt), .smiN(smiN),
    .binitN(binitN), .initN(initN), .lintN(lintN), .pwrState(pwrState),
    .clkEn(clkEn), .ackReq(ackReq), .seqErr(seqErr), .evtReplay(evtReplay)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectReplay(input logic [4:0] code);
    expQ.push_back(code);
  endtask

  // monitor side: pops one expected code per observed replay pulse
  always @(posedge clk) begin
    #2;
    if (rstN === 1'b1 && evtReplay !== 5'd0) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R10 unexpected replay: actual %0h expected 0", evtReplay);
      end else begin
        logic [4:0] e;
        e = expQ.pop_front();
        if (e !== evtReplay) begin
          mismatched++;
          $display("FAIL R10 replay order: actual %0h expected %0h", evtReplay, e);
        end
      end
    end
  end

  task automatic toGrant();
    stpClkN = 1'b0;
    step();
    ackRsp = 1'b1;
    step();
    ackRsp = 1'b0;
    repeat (20) step();
    chk("R5", "state reaches stop-grant", pwrState, 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; cpuReset = 1'b0; haltPulse = 1'b0; stpClkN = 1'b1; slpN = 1'b1;
    snoopHit = 1'b0; snoopDone = 1'b0; ackRsp = 1'b0; rsmPulse = 1'b0;
    rsmToHalt = 1'b0; smiN = 1'b1; binitN = 1'b1; initN = 1'b1; lintN = 2'b11;
    repeat (3) step();
    chk("R1", "reset state", pwrState, 0);
    chk("R1", "reset clkEn", clkEn, 4'hF);
    chk("R1", "reset ackReq", ackReq, 0);
    chk("R1", "reset replay", evtReplay, 0);
    rstN = 1'b1;
    step();
    chk("R1", "idle after reset", pwrState, 0);

    // R2: halt and wake
    haltPulse = 1'b1; step(); haltPulse = 1'b0;
    chk("R2", "halt entry", pwrState, 1);
    chk("R2", "halt clkEn", clkEn, 4'b0011);
    step();
    chk("R2", "halt holds", pwrState, 1);
    smiN = 1'b0; step(); smiN = 1'b1;
    chk("R2", "smi wake", pwrState, 0);
    haltPulse = 1'b1; step(); haltPulse = 1'b0;
    lintN = 2'b10; step(); lintN = 2'b11;
    chk("R2", "local line wake", pwrState, 0);

    // R3: resume target
    rsmPulse = 1'b1; rsmToHalt = 1'b1; step(); rsmPulse = 1'b0;
    chk("R3", "resume to halt", pwrState, 1);
    initN = 1'b0; step(); initN = 1'b1;
    chk("R3", "wake after resume", pwrState, 0);
    rsmPulse = 1'b1; rsmToHalt = 1'b0; step(); rsmPulse = 1'b0;
    chk("R3", "resume to normal", pwrState, 0);

    // R4/R5: acknowledge and delayed entry from AutoHALT
    haltPulse = 1'b1; step(); haltPulse = 1'b0;
    stpClkN = 1'b0; step();
    chk("R4", "ack wait state", pwrState, 2);
    chk("R4", "ackReq high", ackReq, 1);
    step(); step();
    chk("R4", "ackReq held", ackReq, 1);
    ackRsp = 1'b1; step(); ackRsp = 1'b0;
    chk("R5", "enter delay", pwrState, 3);
    chk("R4", "ackReq drops", ackReq, 0);
    repeat (19) step();
    chk("R5", "still delaying at T0+19", pwrState, 3);
    chk("R5", "clocks on at T0+19", clkEn, 4'hF);
    step();
    chk("R5", "stop-grant at T0+20", pwrState, 4);
    chk("R5", "grant clkEn", clkEn, 4'b0001);

    // R10: latch events without servicing
    binitN = 1'b0; initN = 1'b0; step(); binitN = 1'b1; step();
    chk("R10", "not serviced", pwrState, 4);
    chk("R10", "no replay while stopped", evtReplay, 0);
    initN = 1'b1; lintN = 2'b01; step(); lintN = 2'b11;
    smiN = 1'b0; step(); smiN = 1'b1;
    chk("R10", "still stopped", pwrState, 4);

    // R9: snoop
    snoopHit = 1'b1; step(); snoopHit = 1'b0;
    chk("R9", "snoop state", pwrState, 5);
    chk("R9", "snoop clkEn", clkEn, 4'b0011);
    step();
    chk("R9", "snoop holds", pwrState, 5);
    snoopDone = 1'b1; step(); snoopDone = 1'b0;
    chk("R9", "back to grant", pwrState, 4);

    // R8: sleep round trip
    slpN = 1'b0; step();
    chk("R8", "sleep state", pwrState, 6);
    chk("R8", "sleep clkEn", clkEn, 4'b0000);
    slpN = 1'b1; step();
    chk("R8", "sleep exit", pwrState, 4);
    chk("R8", "no sleep error", seqErr, 0);

    // R7 + R10 replay
    expectReplay(5'b00001); expectReplay(5'b00010);
    expectReplay(5'b00100); expectReplay(5'b10000);
    stpClkN = 1'b1; step();
    chk("R7", "return to normal", pwrState, 0);
    chk("R7", "no error", seqErr, 0);
    repeat (6) step();
    chk("R10", "all replays seen", expQ.size(), 0);

    // R6: early release in AckWait and in EnterDelay
    stpClkN = 1'b0; step();
    chk("R6", "ack wait", pwrState, 2);
    stpClkN = 1'b1; step();
    chk("R6", "abort to normal", pwrState, 0);
    chk("R6", "early flag", seqErr, 2'b01);
    step();
    chk("R6", "flag one cycle", seqErr, 0);
    stpClkN = 1'b0; step(); ackRsp = 1'b1; step(); ackRsp = 1'b0;
    repeat (5) step();
    stpClkN = 1'b1; step();
    chk("R6", "abort from delay", pwrState, 0);
    chk("R6", "early flag in delay", seqErr, 2'b01);

    // R8: release with sleep
    toGrant();
    slpN = 1'b0; step();
    chk("R8", "sleep again", pwrState, 6);
    slpN = 1'b1; stpClkN = 1'b1; step();
    chk("R8", "to grant", pwrState, 4);
    chk("R8", "sleep order flag", seqErr, 2'b10);
    step();
    chk("R7", "then normal", pwrState, 0);

    // R11: reset during stop-grant
    toGrant();
    lintN = 2'b10; step(); lintN = 2'b11;
    cpuReset = 1'b1; step();
    chk("R11", "core init", pwrState, 7);
    chk("R11", "init clkEn", clkEn, 4'hF);
    step(); cpuReset = 1'b0; step();
    chk("R11", "stays stop-grant", pwrState, 4);
    stpClkN = 1'b1; step();
    chk("R11", "normal after release", pwrState, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R11", "latched event discarded", evtReplay, 0);
    end
    cpuReset = 1'b1; step();
    chk("R11", "init from normal", pwrState, 7);
    cpuReset = 1'b0; step();
    chk("R11", "normal after init", pwrState, 0);

    // R10: second ordering pattern
    toGrant();
    lintN = 2'b10; smiN = 1'b0; step(); lintN = 2'b11; smiN = 1'b1;
    expectReplay(5'b00100); expectReplay(5'b01000);
    stpClkN = 1'b1; step();
    chk("R7", "normal", pwrState, 0);
    repeat (4) step();
    chk("R10", "second replay drained", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule